// File: doc/BRIEF.md
# Byte-Wide Dual DAC Write Sequencer

This block is a host-side bus master for a two-channel digital-to-analog converter that has an 8-bit data bus and double-buffered latches. A requester hands it one 12-bit code, a channel bit and a load flag over a ready/valid handshake. The sequencer then runs two addressed write cycles on the converter bus: the low eight bits go first and the top four bits follow. If the load flag is set, it then pulses the active-low load strobe that moves the staged codes to both outputs together.

All bus timing is derived from the system clock. The minimum strobe width, the data setup and hold times and the load pulse width are given in nanoseconds. Each is rounded up to whole clock cycles from the clock-frequency parameter. The data hold time grows with the chip-select hold, up to a fixed cap. Setting the load flag on only the last of several requests stages both channels first and updates them at the same moment.

Top module: `dac_byte_sequencer`

## Requirements
- R1: While reset is held, and in the first cycle after it, req_ready is 1, dac_cs_n, dac_wr_n and dac_ld_n are 1, and dac_addr and dac_data are 0.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready stays 0 from that edge until the last strobe of the sequence has ended. It is 1 again in the cycle that follows the final hold or load cycle.
- R3: The first write cycle uses address {chan,0} with data code[7:0]. The second uses address {chan,1} with data {4'b0000, code[11:8]}. Channel A is chan=0 and channel B is chan=1.
- R4: dac_wr_n is low for WRL consecutive cycles per write. WRL is the larger of ceil(80 ns·f) and ceil(80 ns·f)−1, which is 16 cycles at 200 MHz.
- R5: dac_cs_n and the address go active one cycle before dac_wr_n falls and are released one cycle after dac_wr_n rises.
- R6: dac_data and dac_addr are valid from the cycle in which dac_cs_n falls and stay stable while dac_wr_n is low. This gives at least 80 ns of setup before the rising strobe.
- R7: dac_data stays unchanged for DH cycles after dac_wr_n rises. DH is ceil((10 ns + min(clock period, 10 ns))·f), which is 3 cycles at 200 MHz. The next write cycle starts no earlier than this.
- R8: With the load flag set, dac_ld_n goes low for LD = ceil(80 ns·f) cycles (16 at 200 MHz), starting right after the second write's hold. dac_cs_n and dac_wr_n stay high throughout the pulse.
- R9: With the load flag clear, dac_ld_n stays high for the whole sequence.
- R10: Changes to req_chan, req_code and req_load while req_ready is 0 have no effect on the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_chan | input | 1 | Channel select, 0 = A, 1 = B |
| req_code | input | CODE_W | Code for the selected channel |
| req_load | input | 1 | Pulse the load strobe after the writes |
| dac_cs_n | output | 1 | Converter chip select, active low |
| dac_wr_n | output | 1 | Converter write strobe, active low |
| dac_addr | output | 2 | Latch address {channel, high part} |
| dac_data | output | DATA_W | Converter data bus |
| dac_ld_n | output | 1 | Converter load strobe, active low |

## Verification
The assertions assume that req_valid is only acted on while req_ready is high. They also assume the requester may do anything with the request fields while the sequencer is busy. The bench keeps req_valid high through each whole sequence and inverts every request field as soon as the request has been taken. Any leak of those fields into the bus therefore shows up as a wrong address or data byte. The bench sweeps both channels, both load settings and all sixteen high-nibble values with varied low bytes. It compares every bus signal on every cycle against a timeline computed from the cycle-count formulas.

// File: rtl/dacseq_pkg.sv
`timescale 1ns/1ps
// Shared types and cycle-count helpers for the DAC write sequencer.
// Assumes clock frequency is given in whole MHz.
package dacseq_pkg;

    // State encoding: bit0 = chip select active, bit1 = write strobe active,
    // bit2 = load strobe active, bit3 = post-strobe phase. Strobes come
    // straight from flops, so the bus pins never glitch.
    typedef enum logic [3:0] {
        ST_IDLE   = 4'b0000,
        ST_PREP   = 4'b0001,
        ST_STROBE = 4'b0011,
        ST_CSHOLD = 4'b1001,
        ST_DHOLD  = 4'b1000,
        ST_LOAD   = 4'b0100
    } seq_state_t;

    // Minimum time in ns to whole clock cycles, rounded up, at least one.
    function automatic int ns_to_cyc(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    // Data hold: base time plus chip-select hold (one clock period), capped.
    function automatic int hold_cyc(input int base_ns, input int cap_ns, input int mhz);
        int per_ps;
        int add_ps;
        int c;
        per_ps = (1000000 + mhz - 1) / mhz;
        add_ps = (per_ps < cap_ns * 1000) ? per_ps : cap_ns * 1000;
        c = ((base_ns * 1000 + add_ps) * mhz + 999999) / 1000000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/dacseq_timer.sv
`timescale 1ns/1ps
// Down counter that times each strobe and hold phase.
// Assumes load values fit in CNT_W bits; holds at zero when not loaded.
module dacseq_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    // Load a phase length or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/dacseq_ctrl.sv
`timescale 1ns/1ps
// Sequencing FSM: takes a request, runs low-byte and high-part write cycles,
// then an optional load pulse. Assumes WRL, DH, LD are at least one cycle.
module dacseq_ctrl
    import dacseq_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int WRL    = 16,
    parameter int DH     = 3,
    parameter int LD     = 16,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_chan,
    input  logic [CODE_W-1:0] req_code,
    input  logic              req_load,
    output seq_state_t        state,
    output logic              hi,
    output logic              chan,
    output logic [CODE_W-1:0] code
);
    seq_state_t       nxt;
    logic             ld_flag;
    logic             accept;
    logic             adv_byte;
    logic             finish;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;

    dacseq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    // Next-state and timer-load decision.
    always_comb begin
        nxt      = state;
        accept   = 1'b0;
        adv_byte = 1'b0;
        finish   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state)
            ST_IDLE: if (req_valid) begin
                nxt    = ST_PREP;
                accept = 1'b1;
            end
            ST_PREP: begin
                nxt      = ST_STROBE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(WRL - 1);
            end
            ST_STROBE: if (tmr_zero) nxt = ST_CSHOLD;
            ST_CSHOLD: begin
                if (DH > 1) begin
                    nxt      = ST_DHOLD;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(DH - 2);
                end else begin
                    finish = 1'b1;
                end
            end
            ST_DHOLD: if (tmr_zero) finish = 1'b1;
            ST_LOAD:  if (tmr_zero) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
        if (finish) begin
            if (!hi) begin
                nxt      = ST_PREP;
                adv_byte = 1'b1;
            end else if (ld_flag) begin
                nxt      = ST_LOAD;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(LD - 1);
            end else begin
                nxt = ST_IDLE;
            end
        end
    end

    // State register and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            hi      <= 1'b0;
            chan    <= 1'b0;
            code    <= '0;
            ld_flag <= 1'b0;
        end else begin
            state <= nxt;
            if (accept) begin
                chan    <= req_chan;
                code    <= req_code;
                ld_flag <= req_load;
                hi      <= 1'b0;
            end else if (adv_byte) begin
                hi <= 1'b1;
            end
        end
    end

    // R2: the high part is never written before a low byte of the same request.
    p_low_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req_valid) |=> (state == ST_PREP && !hi));
endmodule

// File: rtl/dacseq_drive.sv
`timescale 1ns/1ps
// Bus decode: strobes taken from state bits, address and data muxed from the
// captured request. Assumes code changes only while idle.
module dacseq_drive
    import dacseq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        state,
    input  logic              hi,
    input  logic              chan,
    input  logic [CODE_W-1:0] code,
    output logic              req_ready,
    output logic              dac_cs_n,
    output logic              dac_wr_n,
    output logic              dac_ld_n,
    output logic [1:0]        dac_addr,
    output logic [DATA_W-1:0] dac_data
);
    logic [3:0] sbits;

    assign sbits = state;

    // Pin decode from the state encoding and the captured request.
    always_comb begin
        req_ready = (state == ST_IDLE);
        dac_cs_n  = ~sbits[0];
        dac_wr_n  = ~sbits[1];
        dac_ld_n  = ~sbits[2];
        dac_addr  = {chan, hi};
        dac_data  = hi ? DATA_W'(code >> DATA_W) : code[DATA_W-1:0];
    end

    // R6: address and data do not move while the write strobe is low.
    p_strobe_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_wr_n && $past(!dac_wr_n)) |-> ($stable(dac_data) && $stable(dac_addr)));
endmodule

// File: rtl/dac_byte_sequencer.sv
`timescale 1ns/1ps
// Top: timed write sequencer for a byte-wide, double-buffered dual DAC.
// Converts nanosecond minimums to cycles from CLK_MHZ; assumes CODE_W <= 2*DATA_W.
module dac_byte_sequencer
    import dacseq_pkg::*;
#(
    parameter int CLK_MHZ         = 200,
    parameter int DATA_W          = 8,
    parameter int CODE_W          = 12,
    parameter int WR_MIN_NS       = 80,
    parameter int SETUP_MIN_NS    = 80,
    parameter int HOLD_MIN_NS     = 10,
    parameter int HOLD_ADD_CAP_NS = 10,
    parameter int LD_MIN_NS       = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_chan,
    input  logic [CODE_W-1:0] req_code,
    input  logic              req_load,
    output logic              dac_cs_n,
    output logic              dac_wr_n,
    output logic [1:0]        dac_addr,
    output logic [DATA_W-1:0] dac_data,
    output logic              dac_ld_n
);
    localparam int WR_C  = ns_to_cyc(WR_MIN_NS, CLK_MHZ);
    localparam int SU_C  = ns_to_cyc(SETUP_MIN_NS, CLK_MHZ);
    localparam int WRL   = (WR_C > SU_C - 1) ? WR_C : SU_C - 1;
    localparam int DH    = hold_cyc(HOLD_MIN_NS, HOLD_ADD_CAP_NS, CLK_MHZ);
    localparam int LD    = ns_to_cyc(LD_MIN_NS, CLK_MHZ);
    localparam int MAXC  = (WRL > LD) ? ((WRL > DH) ? WRL : DH) : ((LD > DH) ? LD : DH);
    localparam int CNT_W = $clog2(MAXC + 1);

    seq_state_t        state;
    logic              hi;
    logic              chan;
    logic [CODE_W-1:0] code;

    dacseq_ctrl #(
        .CODE_W (CODE_W), .WRL (WRL), .DH (DH), .LD (LD), .CNT_W (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_chan  (req_chan),
        .req_code  (req_code),
        .req_load  (req_load),
        .state     (state),
        .hi        (hi),
        .chan      (chan),
        .code      (code)
    );

    dacseq_drive #(.DATA_W (DATA_W), .CODE_W (CODE_W)) u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .hi        (hi),
        .chan      (chan),
        .code      (code),
        .req_ready (req_ready),
        .dac_cs_n  (dac_cs_n),
        .dac_wr_n  (dac_wr_n),
        .dac_ld_n  (dac_ld_n),
        .dac_addr  (dac_addr),
        .dac_data  (dac_data)
    );

    // Checker counters for pulse widths and data hold.
    logic [15:0] wr_low_cnt;
    logic [15:0] ld_low_cnt;
    logic [15:0] since_rise;
    logic        seen_wr;

    // Track strobe low lengths and cycles since the write strobe went high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_low_cnt <= '0;
            ld_low_cnt <= '0;
            since_rise <= '0;
            seen_wr    <= 1'b0;
        end else begin
            wr_low_cnt <= dac_wr_n ? 16'd0 : wr_low_cnt + 16'd1;
            ld_low_cnt <= dac_ld_n ? 16'd0 : ld_low_cnt + 16'd1;
            if (!dac_wr_n)               since_rise <= '0;
            else if (since_rise != 16'hFFFF) since_rise <= since_rise + 16'd1;
            if (!dac_wr_n) seen_wr <= 1'b1;
        end
    end

    // R2: an accepted request makes the block busy and selects the chip.
    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !dac_cs_n));
    // R2: an idle block drives no strobe.
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (dac_cs_n && dac_wr_n && dac_ld_n));
    // R4: each write strobe lasts exactly WRL cycles.
    p_wr_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_wr_n) |-> (wr_low_cnt == 16'(WRL)));
    // R5: chip select frames the write strobe on both edges.
    p_cs_frames_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_wr_n || $rose(dac_wr_n)) |-> !dac_cs_n);
    p_cs_before_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_wr_n) |-> $past(!dac_cs_n));
    // R7: data is held DH cycles after the strobe rises.
    p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_wr && !$stable(dac_data)) |-> (since_rise >= 16'(DH)));
    // R8: load pulse never overlaps a write and lasts exactly LD cycles.
    p_load_alone_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_ld_n |-> (dac_cs_n && dac_wr_n));
    p_ld_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_ld_n) |-> (ld_low_cnt == 16'(LD)));
endmodule

// File: tb/dac_byte_sequencer_bench.sv
`timescale 1ns/1ps
module dac_byte_sequencer_bench;
    localparam int MHZ    = 200;
    localparam int WRC    = (80 * MHZ + 999) / 1000;
    localparam int SUC    = (80 * MHZ + 999) / 1000;
    localparam int WRL    = (WRC > SUC - 1) ? WRC : SUC - 1;
    localparam int PER_PS = 1000000 / MHZ;
    localparam int DHC    = ((10000 + ((PER_PS < 10000) ? PER_PS : 10000)) * MHZ + 999999) / 1000000;
    localparam int LDC    = (80 * MHZ + 999) / 1000;
    localparam int BYTE_T = WRL + DHC + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_chan = 1'b0;
    logic [11:0] req_code = '0;
    logic        req_load = 1'b0;
    logic        dac_cs_n, dac_wr_n, dac_ld_n;
    logic [1:0]  dac_addr;
    logic [7:0]  dac_data;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    dac_byte_sequencer u_dac_byte_sequencer (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_chan (req_chan), .req_code (req_code), .req_load (req_load),
        .dac_cs_n (dac_cs_n), .dac_wr_n (dac_wr_n),
        .dac_addr (dac_addr), .dac_data (dac_data), .dac_ld_n (dac_ld_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One request; compares every bus signal each cycle against the timeline.
    task automatic run_req(input bit ch, input logic [11:0] c, input bit l);
        int total;
        int w;
        w = 0;
        while (!req_ready && w < 1000) begin
            @(negedge clk);
            w++;
        end
        req_valid = 1'b1;
        req_chan  = ch;
        req_code  = c;
        req_load  = l;
        @(negedge clk);
        total = 2 * BYTE_T + (l ? LDC : 0);
        for (int t = 0; t <= total; t++) begin
            bit e_cs, e_wr, e_ld, e_rdy;
            if (t < 2 * BYTE_T) begin
                int bi;
                int bt;
                logic [7:0] e_data;
                bi = t / BYTE_T;
                bt = t % BYTE_T;
                e_cs  = !(bt <= WRL + 1);
                e_wr  = !(bt >= 1 && bt <= WRL);
                e_ld  = 1'b1;
                e_rdy = 1'b0;
                e_data = (bi == 1) ? {4'b0000, c[11:8]} : c[7:0];
                if (!e_cs)
                    chk(dac_addr == {ch, bi[0]}, "R3,R10", "addr", dac_addr, {ch, bi[0]});
                if (bt == 0)
                    chk(dac_data == e_data, "R3", "data", dac_data, e_data);
                else if (bt <= WRL)
                    chk(dac_data == e_data, "R6", "data setup", dac_data, e_data);
                else
                    chk(dac_data == e_data, "R7", "data hold", dac_data, e_data);
            end else if (t < total) begin
                e_cs = 1'b1; e_wr = 1'b1; e_ld = 1'b0; e_rdy = 1'b0;
            end else begin
                e_cs = 1'b1; e_wr = 1'b1; e_ld = 1'b1; e_rdy = 1'b1;
            end
            chk(req_ready == e_rdy, "R2", "ready", req_ready, e_rdy);
            chk(dac_wr_n == e_wr, "R4", "wr_n", dac_wr_n, e_wr);
            chk(dac_cs_n == e_cs, "R5", "cs_n", dac_cs_n, e_cs);
            chk(dac_ld_n == e_ld, l ? "R8" : "R9", "ld_n", dac_ld_n, e_ld);
            if (t == 0) begin
                // R10: scramble the request fields while busy, valid kept high
                req_chan = ~ch;
                req_code = ~c;
                req_load = ~l;
            end
            if (t == total - 1) req_valid = 1'b0;
            if (t < total) @(negedge clk);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready && dac_cs_n && dac_wr_n && dac_ld_n, "R1", "strobes in reset",
            {req_ready, dac_cs_n, dac_wr_n, dac_ld_n}, 4'hF);
        chk(dac_addr == 2'b00 && dac_data == 8'h00, "R1", "bus in reset",
            {dac_addr, dac_data}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && dac_cs_n && dac_wr_n && dac_ld_n, "R1", "strobes after reset",
            {req_ready, dac_cs_n, dac_wr_n, dac_ld_n}, 4'hF);
        chk(dac_addr == 2'b00 && dac_data == 8'h00, "R1", "bus after reset",
            {dac_addr, dac_data}, 0);
        for (int ch = 0; ch < 2; ch++) begin
            for (int l = 0; l < 2; l++) begin
                run_req(ch[0], 12'h000, l[0]);
                run_req(ch[0], 12'hFFF, l[0]);
                for (int k = 0; k < 16; k++) begin
                    logic [7:0] lo;
                    lo = 8'(k * 17) ^ 8'hA5;
                    run_req(ch[0], {k[3:0], lo}, l[0]);
                end
            end
        end
        // stage A and B without load, then one shared load
        run_req(1'b0, 12'h123, 1'b0);
        run_req(1'b1, 12'hABC, 1'b0);
        run_req(1'b0, 12'h800, 1'b1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule